// File: doc/BRIEF.md
# Windowed Watchdog With Failure Counter

This block supervises a host processor through a single trigger line that the host toggles. Any edge counts as a trigger, whether rising or falling. When the supervisor is armed, the first edge must arrive before a start deadline expires. After that, each edge must fall inside a timing window measured from the previous accepted edge. An edge that comes too early, or an edge that does not come in time, starts a reset pulse. Its width is chosen by a two-bit select. The supervisor arms again when that pulse ends. All timing is counted in ticks of a 1 ms strobe.

The block also watches for neglect of the host bus. After a change indication, the host must perform a bus read before two accepted trigger edges have passed. If it does not, a reset pulse is issued and a separate flag is raised.

Watchdog failures and bus misses are counted separately. These counts are never lowered by good behaviour. When either count reaches its limit (five by default), the block drops the power-enable output and raises a one-cycle standby request. It then stops supervising until the mode logic clears the counters. The mode logic also gates the whole block with an enable input, which is low in standby and wait.

Top module: `wdg_window_guard`

## Requirements
- R1: After reset, `rst_pulse` is 0, `pwr_en` is 1, `standby_req` is 0 and both flags are 0.
- R2: Arming happens when `wd_enable` goes high or when a reset pulse ends. After arming, the first trigger edge is accepted if at most FIRST_MS ticks have elapsed. When tick number FIRST_MS+1 arrives without an edge, a reset pulse starts on that clock edge.
- R3: After an accepted edge, the next edge is accepted only when WIN_LO to WIN_HI ticks have elapsed, both ends included. An edge after fewer than WIN_LO ticks starts a reset pulse on the clock edge where it is seen.
- R4: When tick number WIN_HI+1 after an accepted edge arrives without a trigger edge, a reset pulse starts on that clock edge.
- R5: The reset pulse lasts exactly N ticks. N is 20 for `pw_sel`=00, 10 for 01, 5 for 10 and 1 for 11. The select value is captured when the pulse starts, and later changes to it do not affect that pulse.
- R6: Trigger edges that occur while the reset pulse is high are ignored. The start deadline of R2 restarts from zero when the pulse ends.
- R7: A watchdog timing failure sets `wd_flag`. The flag holds until `flag_clr` is pulsed. If a failure and a clear happen in the same cycle, the set wins.
- R8: After a `chg_ind` pulse, if two accepted trigger edges occur with no `host_read` between them, the second edge starts a reset pulse and sets `bus_flag`. A `host_read` in between prevents this.
- R9: Timing failures and bus misses are counted separately, and successful triggers never lower either count. When a count reaches FAIL_LIMIT, `pwr_en` goes to 0 and `standby_req` is high for exactly one cycle. No further checking or new pulses occur until the counters are cleared. The pulse already running finishes.
- R10: `cnt_clr` clears both counters. `bus_clr` clears only the bus-miss counter. `pwr_en` returns to 1 once neither counter is at its limit.
- R11: While `wd_enable` is 0, no reset pulse is produced and no flag is set, whatever the trigger line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| wd_enable | input | 1 | Supervision enable from the mode logic |
| trig_in | input | 1 | Host trigger line; any edge is a trigger |
| pw_sel | input | 2 | Reset pulse width select |
| chg_ind | input | 1 | Pulse: change indication issued to host |
| host_read | input | 1 | Pulse: host completed a bus read |
| cnt_clr | input | 1 | Clears both failure counters (mode entry) |
| bus_clr | input | 1 | Clears the bus-miss counter only |
| flag_clr | input | 1 | Clears both status flags |
| rst_pulse | output | 1 | Reset pulse to the host |
| pwr_en | output | 1 | Power enable; low after too many failures |
| standby_req | output | 1 | One-cycle request to enter standby |
| wd_flag | output | 1 | Sticky: reset caused by trigger timing |
| bus_flag | output | 1 | Sticky: reset caused by a missed bus read |

## Verification
The bench builds the block with FIRST_MS=40, WIN_LO=20 and WIN_HI=30, so each window takes only a few dozen ticks. The bench drives one tick every two clocks. FAIL_LIMIT and all four pulse widths keep their default values, so every width code and the fifth-failure shutdown are reached in one short run. The small windows make it cheap to test the exact boundary ticks: the last tick before the start deadline, WIN_LO and WIN_HI themselves, and the ticks one past each.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      PH_FIRST = 1'b0,
      PH_WIN   = 1'b1
   } wdg_phase_e;

   function automatic int unsigned max_of(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
   parameter int unsigned PW_00 = 20,
   parameter int unsigned PW_01 = 10,
   parameter int unsigned PW_10 = 5,
   parameter int unsigned PW_11 = 1,
   parameter int unsigned CW    = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       start,
   input  logic [1:0] sel,
   output logic       busy
);

   logic [CW-1:0] remain;
   logic [CW-1:0] width_lu;

   always_comb begin
      case (sel)
         2'b00:   width_lu = CW'(PW_00);
         2'b01:   width_lu = CW'(PW_01);
         2'b10:   width_lu = CW'(PW_10);
         default: width_lu = CW'(PW_11);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   remain <= '0;
      else if (!en)                 remain <= '0;
      else if (start)               remain <= width_lu;
      else if (tick && remain != 0) remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/wdg_window_chk.sv
module wdg_window_chk
   import wdg_pkg::*;
#(
   parameter int unsigned FIRST_MS = 500,
   parameter int unsigned WIN_LO   = 200,
   parameter int unsigned WIN_HI   = 300,
   parameter int unsigned W        = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick,
   input  logic trig,
   output logic edge_ok,
   output logic fail
);

   logic          trig_q;
   wdg_phase_e    phase;
   logic [W-1:0]  elapsed;
   logic [W-1:0]  limit_v;
   logic          edge_seen;
   logic          too_early;
   logic          at_limit;

   always_comb begin
      limit_v   = (phase == PH_FIRST) ? W'(FIRST_MS) : W'(WIN_HI);
      edge_seen = active & (trig ^ trig_q);
      too_early = (phase == PH_WIN) && (elapsed < W'(WIN_LO));
      at_limit  = (elapsed == limit_v);
   end

   assign edge_ok = edge_seen & ~too_early;
   assign fail    = (edge_seen & too_early) | (active & ~edge_seen & tick & at_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= 1'b0;
         phase   <= PH_FIRST;
         elapsed <= '0;
      end else begin
         trig_q <= trig;
         if (!active) begin
            phase   <= PH_FIRST;
            elapsed <= '0;
         end else if (edge_seen) begin
            phase   <= PH_WIN;
            elapsed <= '0;
         end else if (tick && !at_limit) begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdg_fail_ctr.sv
module wdg_fail_ctr #(
   parameter int unsigned LIMIT = 5,
   parameter int unsigned CW    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (inc && !full)  cnt <= cnt + 1'b1;
   end

   assign full = (cnt == CW'(LIMIT));

endmodule

// File: rtl/wdg_window_guard.sv
module wdg_window_guard
   import wdg_pkg::*;
#(
   parameter int unsigned FIRST_MS   = 500,
   parameter int unsigned WIN_LO     = 200,
   parameter int unsigned WIN_HI     = 300,
   parameter int unsigned FAIL_LIMIT = 5,
   parameter int unsigned PW_00      = 20,
   parameter int unsigned PW_01      = 10,
   parameter int unsigned PW_10      = 5,
   parameter int unsigned PW_11      = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       wd_enable,
   input  logic       trig_in,
   input  logic [1:0] pw_sel,
   input  logic       chg_ind,
   input  logic       host_read,
   input  logic       cnt_clr,
   input  logic       bus_clr,
   input  logic       flag_clr,
   output logic       rst_pulse,
   output logic       pwr_en,
   output logic       standby_req,
   output logic       wd_flag,
   output logic       bus_flag
);

   localparam int unsigned WCW    = $clog2(max_of(FIRST_MS, WIN_HI) + 1);
   localparam int unsigned PW_MAX = max_of(max_of(PW_00, PW_01), max_of(PW_10, PW_11));
   localparam int unsigned PCW    = $clog2(PW_MAX + 1);
   localparam int unsigned FCW    = $clog2(FAIL_LIMIT + 1);
   localparam int unsigned N_CTR  = 2;

   generate
      if (WIN_LO > WIN_HI)
         $error("wdg_window_guard: WIN_LO must not exceed WIN_HI");
      if (FAIL_LIMIT < 1)
         $error("wdg_window_guard: FAIL_LIMIT must be at least 1");
      if (PW_00 < 1 || PW_01 < 1 || PW_10 < 1 || PW_11 < 1)
         $error("wdg_window_guard: every pulse width must be at least one tick");
   endgenerate

   logic             shutdown, shutdown_q;
   logic             supervise, check_on;
   logic             edge_ok, fail_win, fail_bus, fail_any;
   logic             pend, seen;
   logic [N_CTR-1:0] inc_v, clr_v, full_v;

   assign shutdown  = |full_v;
   assign supervise = wd_enable & ~shutdown;
   assign check_on  = supervise & ~rst_pulse;

   wdg_window_chk #(
      .FIRST_MS (FIRST_MS),
      .WIN_LO   (WIN_LO),
      .WIN_HI   (WIN_HI),
      .W        (WCW)
   ) i_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (check_on),
      .tick    (tick_ms),
      .trig    (trig_in),
      .edge_ok (edge_ok),
      .fail    (fail_win)
   );

   // bus-read supervision across two accepted trigger edges
   assign fail_bus = edge_ok & pend & seen & ~host_read & ~chg_ind;
   assign fail_any = fail_win | fail_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         seen <= 1'b0;
      end else if (!supervise) begin
         pend <= 1'b0;
         seen <= 1'b0;
      end else if (chg_ind) begin
         pend <= 1'b1;
         seen <= 1'b0;
      end else if (host_read || fail_bus) begin
         pend <= 1'b0;
         seen <= 1'b0;
      end else if (edge_ok && pend) begin
         seen <= 1'b1;
      end
   end

   wdg_pulse_gen #(
      .PW_00 (PW_00),
      .PW_01 (PW_01),
      .PW_10 (PW_10),
      .PW_11 (PW_11),
      .CW    (PCW)
   ) i_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wd_enable),
      .tick  (tick_ms),
      .start (fail_any),
      .sel   (pw_sel),
      .busy  (rst_pulse)
   );

   assign inc_v = {fail_bus, fail_win};
   assign clr_v = {cnt_clr | bus_clr, cnt_clr};

   genvar g;
   generate
      for (g = 0; g < N_CTR; g++) begin : g_ctr
         wdg_fail_ctr #(
            .LIMIT (FAIL_LIMIT),
            .CW    (FCW)
         ) i_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_v[g]),
            .inc   (inc_v[g]),
            .full  (full_v[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_flag    <= 1'b0;
         bus_flag   <= 1'b0;
         shutdown_q <= 1'b0;
      end else begin
         shutdown_q <= shutdown;
         if (fail_win)      wd_flag <= 1'b1;
         else if (flag_clr) wd_flag <= 1'b0;
         if (fail_bus)      bus_flag <= 1'b1;
         else if (flag_clr) bus_flag <= 1'b0;
      end
   end

   assign pwr_en      = ~shutdown;
   assign standby_req = shutdown & ~shutdown_q;

endmodule

// File: rtl/wdg_window_guard_chk.sv
module wdg_window_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_ms,
   input logic wd_enable,
   input logic cnt_clr,
   input logic bus_clr,
   input logic flag_clr,
   input logic rst_pulse,
   input logic pwr_en,
   input logic standby_req,
   input logic wd_flag,
   input logic bus_flag
);

   // R5: the pulse only ends on a tick (or when disabled)
   p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pulse && !tick_ms && wd_enable) |=> rst_pulse);

   // R7, R8: a new pulse is always accompanied by a cause flag
   p_pulse_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pulse) |-> (wd_flag || bus_flag));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_flag && !flag_clr) |=> wd_flag);

   p_standby_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |=> !standby_req);

   p_standby_with_power_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |-> !pwr_en);

   p_shutdown_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && !cnt_clr && !bus_clr) |=> !pwr_en);

   p_quiet_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_enable |=> !rst_pulse);

endmodule

bind wdg_window_guard wdg_window_guard_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_ms     (tick_ms),
   .wd_enable   (wd_enable),
   .cnt_clr     (cnt_clr),
   .bus_clr     (bus_clr),
   .flag_clr    (flag_clr),
   .rst_pulse   (rst_pulse),
   .pwr_en      (pwr_en),
   .standby_req (standby_req),
   .wd_flag     (wd_flag),
   .bus_flag    (bus_flag)
);

// File: tb/test_wdg_window_guard.sv
module test_wdg_window_guard;

   localparam int FIRST = 40;
   localparam int LO    = 20;
   localparam int HI    = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic       wd_enable = 1'b0;
   logic       trig_in = 1'b0;
   logic [1:0] pw_sel = 2'b00;
   logic       chg_ind = 1'b0;
   logic       host_read = 1'b0;
   logic       cnt_clr = 1'b0;
   logic       bus_clr = 1'b0;
   logic       flag_clr = 1'b0;
   logic       rst_pulse, pwr_en, standby_req, wd_flag, bus_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit wd;
      bit bus;
      int width;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   wdg_window_guard #(
      .FIRST_MS (FIRST),
      .WIN_LO   (LO),
      .WIN_HI   (HI)
   ) i_wdg_window_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_ms     (tick_ms),
      .wd_enable   (wd_enable),
      .trig_in     (trig_in),
      .pw_sel      (pw_sel),
      .chg_ind     (chg_ind),
      .host_read   (host_read),
      .cnt_clr     (cnt_clr),
      .bus_clr     (bus_clr),
      .flag_clr    (flag_clr),
      .rst_pulse   (rst_pulse),
      .pwr_en      (pwr_en),
      .standby_req (standby_req),
      .wd_flag     (wd_flag),
      .bus_flag    (bus_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int width_of(input logic [1:0] s);
      case (s)
         2'b00:   return 20;
         2'b01:   return 10;
         2'b10:   return 5;
         default: return 1;
      endcase
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         tick_ms = 1'b1; step();
         tick_ms = 1'b0; step();
      end
   endtask

   task automatic toggle();
      trig_in = ~trig_in; step();
   endtask

   task automatic pulse_in(ref logic sig);
      sig = 1'b1; step();
      sig = 1'b0;
   endtask

   task automatic push(input bit wd, input bit bus, input int width);
      exp_t e;
      e.wd = wd; e.bus = bus; e.width = width;
      exp_q.push_back(e);
   endtask

   // monitor: measures every reset pulse in ticks and compares with the queue
   logic mon_prev = 1'b0;
   int   mon_cnt  = 0;
   exp_t mon_exp;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_pulse && !mon_prev) begin
            mon_cnt = tick_ms ? 1 : 0;
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5: unexpected reset pulse, actual=1 expected=0");
               mon_exp.wd = 1'b0; mon_exp.bus = 1'b0; mon_exp.width = 0;
            end else begin
               mon_exp = exp_q.pop_front();
               if (mon_exp.wd)  chk("R7 wd_flag at pulse start", wd_flag, 1);
               if (mon_exp.bus) chk("R8 bus_flag at pulse start", bus_flag, 1);
            end
         end else if (rst_pulse && tick_ms) begin
            mon_cnt++;
         end
         if (!rst_pulse && mon_prev)
            chk("R5 pulse width in ticks", mon_cnt, mon_exp.width);
         mon_prev = rst_pulse;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1
      chk("R1 rst_pulse", rst_pulse, 0);
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 standby_req", standby_req, 0);
      chk("R1 flags", {wd_flag, bus_flag}, 0);

      wd_enable = 1'b1; step();
      tick_n(10); toggle();
      chk("R2 first edge inside deadline", rst_pulse, 0);
      tick_n(25); toggle();
      tick_n(LO); toggle();
      tick_n(HI); toggle();
      chk("R3 edges at window bounds accepted", rst_pulse, 0);

      // R3 early edge
      tick_n(LO - 1);
      push(1, 0, width_of(pw_sel));
      toggle();
      chk("R3 early edge starts pulse", rst_pulse, 1);
      chk("R7 wd_flag set", wd_flag, 1);
      toggle();                          // R6: ignored while pulsing
      tick_n(19);
      chk("R5 pulse still high before last tick", rst_pulse, 1);
      tick_n(1);
      chk("R5 pulse ends after 20 ticks", rst_pulse, 0);
      chk("R7 flag sticky", wd_flag, 1);
      pulse_in(flag_clr);
      chk("R7 flag cleared", wd_flag, 0);

      // R6 deadline restarted, in-pulse edge not counted
      tick_n(FIRST - 1); toggle();
      chk("R6 restart after pulse", rst_pulse, 0);

      // R4 late edge with width 01
      pw_sel = 2'b01;
      tick_n(HI);
      chk("R4 no pulse at WIN_HI", rst_pulse, 0);
      push(1, 0, 10);
      tick_n(1);
      chk("R4 missing edge starts pulse", rst_pulse, 1);
      tick_n(10);
      chk("R5 width 01 finished", rst_pulse, 0);

      // R2 missed first deadline, width 10 latched
      pw_sel = 2'b10;
      tick_n(FIRST);
      chk("R2 no pulse at deadline", rst_pulse, 0);
      push(1, 0, 5);
      tick_n(1);
      chk("R2 missed deadline starts pulse", rst_pulse, 1);
      pw_sel = 2'b11;
      tick_n(5);
      chk("R5 width captured at start", rst_pulse, 0);

      // fourth failure, width 11
      tick_n(5); toggle();
      push(1, 0, 1);
      tick_n(HI + 1);
      chk("R4 pulse with width 11", rst_pulse, 1);
      tick_n(1);
      chk("R5 one-tick pulse ended", rst_pulse, 0);
      chk("R9 power still on after four failures", pwr_en, 1);

      // R8 bus read supervision
      pulse_in(flag_clr);
      tick_n(5); toggle();
      pulse_in(chg_ind);
      tick_n(LO); toggle();
      pulse_in(host_read);
      tick_n(LO); toggle();
      chk("R8 read between triggers prevents reset", rst_pulse, 0);
      pulse_in(chg_ind);
      tick_n(LO); toggle();
      chk("R8 one trigger after indication is fine", rst_pulse, 0);
      tick_n(LO);
      push(0, 1, 1);
      toggle();
      chk("R8 missed read starts pulse", rst_pulse, 1);
      chk("R8 bus_flag set", bus_flag, 1);
      chk("R8 wd_flag untouched", wd_flag, 0);
      tick_n(1);

      // R9 fifth watchdog failure
      tick_n(FIRST);
      push(1, 0, 1);
      tick_ms = 1'b1; step(); tick_ms = 1'b0;
      chk("R9 standby_req raised", standby_req, 1);
      chk("R9 pwr_en dropped", pwr_en, 0);
      step();
      chk("R9 standby_req single cycle", standby_req, 0);
      tick_n(1);
      chk("R9 final pulse completed", rst_pulse, 0);
      tick_n(60);
      chk("R9 checking stopped", rst_pulse, 0);
      chk("R9 power stays off", pwr_en, 0);

      // R10
      pulse_in(bus_clr); step();
      chk("R10 bus_clr leaves watchdog count", pwr_en, 0);
      pulse_in(cnt_clr); step();
      chk("R10 cnt_clr restores power", pwr_en, 1);
      tick_n(5); toggle();
      chk("R10 supervision resumes", rst_pulse, 0);

      // R11
      pulse_in(flag_clr);
      wd_enable = 1'b0; step();
      toggle(); toggle();
      tick_n(FIRST + 20);
      toggle();
      chk("R11 no pulse while disabled", rst_pulse, 0);
      chk("R11 no flags while disabled", {wd_flag, bus_flag}, 0);

      repeat (4) step();
      chk("R5 all expected pulses seen", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end, actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule